// File: doc/BRIEF.md
# Presence Change Event Scanner

This block watches a 16-slot occupancy mask and tells a consumer which slots have changed since the last time they were reported. It keeps a register of acknowledged occupancy. When a scan is requested, it samples the live occupancy mask and XORs it with the acknowledged register to find the slots that changed. It then writes the sample into the acknowledged register at once. After that it hands out one event per changed slot. Each event carries the slot number and a code that says whether the slot became occupied (insert) or empty (eject).

Events leave through a valid/ready handshake. They go out lowest slot first, and each stays on the outputs until the consumer accepts it. A busy flag covers the interval from a scan request to the acceptance of the final event. A request that arrives during a scan is remembered and served when the current scan ends. Any occupancy change that occurs during a scan is therefore reported by the following scan.

Top module: `presence_scanner`

## Requirements
- R1: After reset, evt_valid_o and busy_o are 0 and ack_mask_o equals the ACK_INIT parameter (default all zero).
- R2: A one-cycle pulse on scan_i makes busy_o 1 in the next cycle. The occupancy mask is sampled on the following clock edge.
- R3: At that sampling edge, ack_mask_o takes the sampled occupancy value. It keeps that value for as long as the scan's events are pending.
- R4: Exactly one event is produced for each bit set in (sample XOR previous acknowledged mask). Unchanged slots produce no event.
- R5: Within a scan, events appear in strictly ascending slot order, starting at slot 0.
- R6: evt_code_o is 2'd1 (insert) when the slot's sampled bit is 1, and 2'd3 (eject) when it is 0. No other code ever appears while evt_valid_o is 1.
- R7: While evt_valid_o is 1 and evt_ready_i is 0, evt_valid_o, evt_slot_o and evt_code_o hold their values.
- R8: After the last event of a scan is accepted, evt_valid_o drops in the next cycle. busy_o also drops then, unless another scan request is pending.
- R9: A scan_i pulse during a scan is remembered, and a new scan starts after the current one finishes. That scan samples the occupancy mask as it stands at that later time.
- R10: A scan that finds no differences raises busy_o for exactly one cycle, emits no event and leaves ack_mask_o at the sampled value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| present_i | input | 16 | Live occupancy mask, one bit per slot |
| scan_i | input | 1 | Scan request pulse |
| evt_ready_i | input | 1 | Consumer accepts the current event |
| evt_valid_o | output | 1 | An event is on offer |
| evt_slot_o | output | 4 | Slot number of the current event |
| evt_code_o | output | 2 | 1 = insert, 3 = eject |
| busy_o | output | 1 | A scan is pending or in progress |
| ack_mask_o | output | 16 | Acknowledged occupancy register |

## Verification
The bench targets mixed insert and eject patterns that include slot 0 and slot 15. A design that scans from the wrong end, or that misses the top bit, would emit events in the wrong order or lose one. It also holds back ready for several cycles. A design that advances on valid alone would skip events or change the slot while it waits.

It issues a scan request while a scan is running and changes the mask at the same time. A design that drops the request would leave busy_o low and never report the second change. A design that samples too early would report the new mask within the old scan.

A scan with no differences checks that busy_o pulses for exactly one cycle and that no spurious event appears.

// File: rtl/presence_scan_pkg.sv
package presence_scan_pkg;

    localparam logic [1:0] CODE_INSERT = 2'd1;
    localparam logic [1:0] CODE_EJECT  = 2'd3;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } scan_state_e;

endpackage

// File: rtl/pcs_lowest_set.sv
// Finds the index of the lowest set bit of a vector.
module pcs_lowest_set #(
    parameter int W = 16,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec_i,
    output logic [IW-1:0] idx_o,
    output logic          any_o
);
    always_comb begin
        idx_o = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                idx_o = IW'(i);
            end
        end
        any_o = |vec_i;
    end
endmodule

// File: rtl/pcs_event_encode.sv
// Turns the acknowledged bit of the selected slot into an event code.
module pcs_event_encode
    import presence_scan_pkg::*;
#(
    parameter int W = 16,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  level_i,
    input  logic [IW-1:0] idx_i,
    output logic [1:0]    code_o
);
    always_comb begin
        code_o = level_i[idx_i] ? CODE_INSERT : CODE_EJECT;
    end
endmodule

// File: rtl/presence_scanner.sv
module presence_scanner
    import presence_scan_pkg::*;
#(
    parameter int               SLOTS    = 16,
    parameter logic [SLOTS-1:0] ACK_INIT = '0,
    localparam int              IDX_W    = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SLOTS-1:0] present_i,
    input  logic             scan_i,
    input  logic             evt_ready_i,
    output logic             evt_valid_o,
    output logic [IDX_W-1:0] evt_slot_o,
    output logic [1:0]       evt_code_o,
    output logic             busy_o,
    output logic [SLOTS-1:0] ack_mask_o
);
    typedef struct packed {
        scan_state_e      st;
        logic             trig;
        logic [SLOTS-1:0] ack;
        logic [SLOTS-1:0] pend;
    } scan_regs_t;

    scan_regs_t       r_q, r_d;
    logic [IDX_W-1:0] head_idx;
    logic             head_any;
    logic [SLOTS-1:0] head_mask;
    logic [SLOTS-1:0] diff;
    logic [1:0]       head_code;

    pcs_lowest_set #(.W(SLOTS)) u_lowest (
        .vec_i (r_q.pend),
        .idx_o (head_idx),
        .any_o (head_any)
    );

    // During a scan the acknowledged register equals the scan's snapshot.
    pcs_event_encode #(.W(SLOTS)) u_encode (
        .level_i (r_q.ack),
        .idx_i   (head_idx),
        .code_o  (head_code)
    );

    always_comb begin
        r_d       = r_q;
        diff      = present_i ^ r_q.ack;
        head_mask = SLOTS'(1) << head_idx;
        r_d.trig  = r_q.trig | scan_i;
        case (r_q.st)
            ST_IDLE: begin
                if (r_q.trig) begin
                    r_d.ack  = present_i;
                    r_d.pend = diff;
                    r_d.trig = scan_i;
                    if (|diff) begin
                        r_d.st = ST_EMIT;
                    end
                end
            end
            ST_EMIT: begin
                if (evt_ready_i) begin
                    r_d.pend = r_q.pend & ~head_mask;
                    if (r_d.pend == '0) begin
                        r_d.st = ST_IDLE;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= ST_IDLE;
            r_q.trig <= 1'b0;
            r_q.ack  <= ACK_INIT;
            r_q.pend <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign evt_valid_o = (r_q.st == ST_EMIT) && head_any;
    assign evt_slot_o  = head_idx;
    assign evt_code_o  = head_code;
    assign busy_o      = (r_q.st == ST_EMIT) | r_q.trig;
    assign ack_mask_o  = r_q.ack;

endmodule

// File: rtl/presence_scanner_checker.sv
module presence_scanner_checker #(
    parameter int SLOTS = 16,
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scan_i,
    input logic             evt_ready_i,
    input logic             evt_valid_o,
    input logic [IDX_W-1:0] evt_slot_o,
    input logic [1:0]       evt_code_o,
    input logic             busy_o,
    input logic [SLOTS-1:0] ack_mask_o
);
    a_r2_request_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        scan_i |=> busy_o);

    a_r3_ack_stable_in_scan: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid_o && $past(evt_valid_o)) |-> $stable(ack_mask_o));

    a_r5_ascending_slots: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid_o && evt_ready_i) |=> (!evt_valid_o || (evt_slot_o > $past(evt_slot_o))));

    a_r6_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid_o |-> (evt_code_o == 2'd1 || evt_code_o == 2'd3));

    a_r6_code_matches_level: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid_o |-> ((evt_code_o == 2'd1) == ack_mask_o[evt_slot_o]));

    a_r7_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid_o && !evt_ready_i) |=>
            (evt_valid_o && $stable(evt_slot_o) && $stable(evt_code_o)));

    a_r8_busy_covers_valid: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid_o |-> busy_o);
endmodule

bind presence_scanner presence_scanner_checker #(.SLOTS(SLOTS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scan_i      (scan_i),
    .evt_ready_i (evt_ready_i),
    .evt_valid_o (evt_valid_o),
    .evt_slot_o  (evt_slot_o),
    .evt_code_o  (evt_code_o),
    .busy_o      (busy_o),
    .ack_mask_o  (ack_mask_o)
);

// File: tb/presence_scanner_bench.sv
module presence_scanner_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] present_i = '0;
    logic        scan_i = 1'b0;
    logic        evt_ready_i = 1'b0;
    logic        evt_valid_o;
    logic [3:0]  evt_slot_o;
    logic [1:0]  evt_code_o;
    logic        busy_o;
    logic [15:0] ack_mask_o;

    int checks = 0;
    int errors = 0;
    logic [15:0] model_ack = '0;

    always #5 clk = ~clk;

    presence_scanner u_presence_scanner (
        .clk, .rst_n, .present_i, .scan_i, .evt_ready_i,
        .evt_valid_o, .evt_slot_o, .evt_code_o, .busy_o, .ack_mask_o
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Pulse scan_i with the given mask. Returns at the negedge after the
    // sampling edge, where ack and the first event are visible.
    task automatic start_scan(input logic [15:0] p);
        @(negedge clk);
        present_i = p;
        scan_i = 1'b1;
        @(negedge clk);
        scan_i = 1'b0;
        check(busy_o == 1'b1, "R2", "busy after request", busy_o, 1);
        @(negedge clk);
        check(ack_mask_o == p, "R3", "ack takes snapshot", ack_mask_o, p);
    endtask

    // Consume the events for a difference vector; stall cycles before each accept.
    task automatic drain(input logic [15:0] diff, input logic [15:0] snap, input int stall);
        for (int i = 0; i < 16; i++) begin
            if (diff[i]) begin
                check(evt_valid_o == 1'b1, "R4", "event present", evt_valid_o, 1);
                check(evt_slot_o == 4'(i), "R5", "slot order", evt_slot_o, i);
                check(evt_code_o == (snap[i] ? 2'd1 : 2'd3), "R6", "event code",
                      evt_code_o, snap[i] ? 1 : 3);
                for (int s = 0; s < stall; s++) begin
                    @(negedge clk);
                    check(evt_valid_o && evt_slot_o == 4'(i), "R7", "hold while stalled",
                          evt_slot_o, i);
                    check(ack_mask_o == snap, "R3", "ack stable in scan", ack_mask_o, snap);
                end
                evt_ready_i = 1'b1;
                @(negedge clk);
                evt_ready_i = 1'b0;
            end
        end
        check(evt_valid_o == 1'b0, "R8", "valid drops after last", evt_valid_o, 0);
    endtask

    task automatic t_reset;
        check(evt_valid_o == 1'b0, "R1", "reset valid", evt_valid_o, 0);
        check(busy_o == 1'b0, "R1", "reset busy", busy_o, 0);
        check(ack_mask_o == 16'h0000, "R1", "reset ack", ack_mask_o, 0);
    endtask

    task automatic t_scan(input logic [15:0] p, input int stall);
        logic [15:0] d;
        d = p ^ model_ack;
        model_ack = p;
        start_scan(p);
        drain(d, p, stall);
        check(busy_o == 1'b0, "R8", "busy drops", busy_o, 0);
    endtask

    task automatic t_no_diff;
        @(negedge clk);
        scan_i = 1'b1;
        @(negedge clk);
        scan_i = 1'b0;
        check(busy_o == 1'b1, "R10", "busy one cycle", busy_o, 1);
        @(negedge clk);
        check(busy_o == 1'b0, "R10", "busy back low", busy_o, 0);
        check(evt_valid_o == 1'b0, "R10", "no event", evt_valid_o, 0);
        check(ack_mask_o == model_ack, "R10", "ack unchanged", ack_mask_o, model_ack);
    endtask

    task automatic t_retrigger(input logic [15:0] p1, input logic [15:0] p2);
        logic [15:0] d1;
        logic [15:0] d2;
        d1 = p1 ^ model_ack;
        d2 = p2 ^ p1;
        model_ack = p2;
        start_scan(p1);
        present_i = p2;
        scan_i = 1'b1;
        @(negedge clk);
        scan_i = 1'b0;
        check(ack_mask_o == p1, "R9", "mid-scan change not sampled", ack_mask_o, p1);
        drain(d1, p1, 0);
        check(busy_o == 1'b1, "R9", "pending request keeps busy", busy_o, 1);
        @(negedge clk);
        check(ack_mask_o == p2, "R9", "second scan snapshot", ack_mask_o, p2);
        drain(d2, p2, 1);
        check(busy_o == 1'b0, "R8", "busy drops after second", busy_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_scan(16'h8001, 0);  // slot 0 and slot 15 inserts
        t_scan(16'h00F0, 2);  // mixed: ejects 0,15; inserts 4..7; stalls
        t_no_diff();
        t_scan(16'hA5A5, 1);
        t_scan(16'h0000, 0);  // all ejects
        t_retrigger(16'h0102, 16'h0100);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual running expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule